// File: doc/BRIEF.md
# Sparse Multipath Channel Filter with Atomic Profile Reload

This block is the time-domain filter of one transmit-to-receive link inside a hardware fading emulator. It takes a stream of signed 14-bit baseband samples and convolves it with a sparse multipath impulse response. The response spans fifteen sample delays, but only nine delay positions carry a path: 0, 2, 4, 5, 7, 9, 11, 13 and 14. So nine multipliers are enough. The result is rounded, saturated to a 17-bit signed value and passed to a later truncation stage.

The impulse response changes over time, about eighteen times a second, to model a slowly varying channel. A host writes each new profile through a simple word interface into a shadow coefficient bank. The sequence is nine coefficient words and then one commit word. A valid commit arms a swap. The swap copies the whole shadow bank into the active bank at the next accepted sample. Samples keep flowing during the load, and no output ever mixes coefficients from two profiles.

Top module: `sparse_mp_fir`

## Requirements
- R1: After reset, out_valid is 0, out_data is 0, both coefficient banks hold zero and no swap is armed, so every output is 0 until a profile has been committed and applied.
- R2: Each output equals the sum over the nine paths k = 0..8 of coefficient k times the input sample that is d_k samples older, with d = 0, 2, 4, 5, 7, 9, 11, 13, 14. Samples at delays 1, 3, 6, 8, 10 and 12 have no effect.
- R3: The delay line advances only in cycles where in_valid is 1. Idle cycles between samples do not change any later output.
- R4: Each accepted sample produces exactly one output. out_valid is 1 in the fourth clock cycle after the cycle in which in_valid was 1, and out_valid is never 1 otherwise.
- R5: The 34-bit sum is rounded by adding 2^14 and then shifting arithmetically right by 15, which rounds halves toward positive infinity.
- R6: The rounded value is saturated to the range -65536 to 65535.
- R7: A load word has an index on ld_idx. Indices 0 to 8 write the coefficient for path k = index, and index 9 is the commit. A commit arms a swap only if indices 0, 1, ..., 8 arrived in that order since the last index-0 word. An index-0 word always restarts the sequence.
- R8: An armed swap takes effect at the next accepted sample. That sample and all later samples use the new coefficients, and all earlier samples use the old ones.
- R9: A commit after an incomplete sequence, an out-of-order index or an index above 9 is discarded, and the active coefficients stay unchanged.
- R10: While a swap is armed, all load words are ignored. They change neither the shadow bank nor the sequence state.
- R11: Coefficient words written before a commit do not affect any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 14 | Signed input sample |
| ld_valid | input | 1 | Load word strobe |
| ld_idx | input | 4 | Load word index (0..8 coefficient, 9 commit) |
| ld_word | input | 16 | Signed coefficient; ignored for the commit word |
| out_valid | output | 1 | Output strobe |
| out_data | output | 17 | Rounded, saturated signed filter output |

## Verification
The assertions run on every cycle. They check that the delay line holds still without a strobe and that the four-cycle output latency holds in both directions. They also check that a swap is armed only by an index-9 word, that it clears on the next sample and carries the shadow bank across, that the active bank changes at no other time, and that the shadow bank is frozen while a swap is armed. The arithmetic, in contrast, can only be shown by the bench's scenarios. These cover the sparse tap positions seen in an impulse response, rounding of exact halves, saturation at both rails, the exact sample at which a new profile takes over, loads interleaved with streaming, and the rejection of broken, incomplete and locked-out load sequences.

// File: rtl/sfir_pkg.sv
package sfir_pkg;

    localparam int NUM_TAPS   = 9;
    localparam int LINE_LEN   = 15;
    localparam int SAMPLE_W   = 14;
    localparam int COEF_W     = 16;
    localparam int OUT_W      = 17;
    localparam int FRAC_SHIFT = 15;

    // Sample delay carried by multiplier k; the order is the load index order.
    function automatic int tap_delay(input int k);
        case (k)
            0:       return 0;
            1:       return 2;
            2:       return 4;
            3:       return 5;
            4:       return 7;
            5:       return 9;
            6:       return 11;
            7:       return 13;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/sfir_delay_line.sv
module sfir_delay_line #(
    parameter int SAMPLE_W = sfir_pkg::SAMPLE_W,
    parameter int LINE_LEN = sfir_pkg::LINE_LEN,
    parameter int NUM_TAPS = sfir_pkg::NUM_TAPS
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               shift_i,
    input  logic [SAMPLE_W-1:0]                sample_i,
    output logic [NUM_TAPS-1:0][SAMPLE_W-1:0]  taps_o,
    output logic                               vld_o
);

    typedef struct packed {
        logic [LINE_LEN-1:0][SAMPLE_W-1:0] line;
        logic                              vld;
    } dl_t;

    dl_t dl_d, dl_q;

    always_comb begin
        dl_d     = dl_q;
        dl_d.vld = shift_i;
        if (shift_i) begin
            dl_d.line = {dl_q.line[LINE_LEN-2:0], sample_i};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dl_q <= '0;
        end else begin
            dl_q <= dl_d;
        end
    end

    for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
        assign taps_o[k] = dl_q.line[sfir_pkg::tap_delay(k)];
    end

    assign vld_o = dl_q.vld;

    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_i |=> $stable(dl_q.line)); // R3

endmodule

// File: rtl/sfir_coef_bank.sv
module sfir_coef_bank #(
    parameter int COEF_W   = sfir_pkg::COEF_W,
    parameter int NUM_TAPS = sfir_pkg::NUM_TAPS,
    parameter int IDX_W    = $clog2(NUM_TAPS + 1)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              ld_valid_i,
    input  logic [IDX_W-1:0]                  ld_idx_i,
    input  logic [COEF_W-1:0]                 ld_word_i,
    input  logic                              swap_i,
    output logic [NUM_TAPS-1:0][COEF_W-1:0]   active_o
);

    localparam logic [IDX_W-1:0] COMMIT_IDX = IDX_W'(NUM_TAPS);

    typedef struct packed {
        logic [NUM_TAPS-1:0][COEF_W-1:0] shadow;
        logic [NUM_TAPS-1:0][COEF_W-1:0] active;
        logic                            seq_ok;
        logic [IDX_W-1:0]                next_idx;
        logic                            pending;
    } bank_t;

    bank_t bk_d, bk_q;

    always_comb begin
        bk_d = bk_q;
        // Whole-profile swap at a sample boundary.
        if (bk_q.pending && swap_i) begin
            bk_d.active  = bk_q.shadow;
            bk_d.pending = 1'b0;
        end
        // Load words are locked out while a swap is armed.
        if (ld_valid_i && !bk_q.pending) begin
            if (ld_idx_i == '0) begin
                bk_d.shadow[0] = ld_word_i;
                bk_d.seq_ok    = 1'b1;
                bk_d.next_idx  = IDX_W'(1);
            end else if (bk_q.seq_ok && (ld_idx_i == bk_q.next_idx)) begin
                if (ld_idx_i == COMMIT_IDX) begin
                    bk_d.pending = 1'b1;
                    bk_d.seq_ok  = 1'b0;
                end else begin
                    bk_d.shadow[ld_idx_i] = ld_word_i;
                    bk_d.next_idx         = bk_q.next_idx + 1'b1;
                end
            end else begin
                bk_d.seq_ok = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bk_q <= '0;
        end else begin
            bk_q <= bk_d;
        end
    end

    assign active_o = bk_q.active;

    AST_ARM_BY_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bk_q.pending) |-> $past(ld_valid_i && (ld_idx_i == COMMIT_IDX))); // R7

    AST_SWAP_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bk_q.pending && swap_i) |=> (!bk_q.pending && (bk_q.active == $past(bk_q.shadow)))); // R8

    AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bk_q.pending && swap_i) |=> $stable(bk_q.active)); // R9

    AST_SHADOW_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        bk_q.pending |=> $stable(bk_q.shadow)); // R10

endmodule

// File: rtl/sfir_mac_pipe.sv
module sfir_mac_pipe #(
    parameter int SAMPLE_W   = sfir_pkg::SAMPLE_W,
    parameter int COEF_W     = sfir_pkg::COEF_W,
    parameter int OUT_W      = sfir_pkg::OUT_W,
    parameter int NUM_TAPS   = sfir_pkg::NUM_TAPS,
    parameter int FRAC_SHIFT = sfir_pkg::FRAC_SHIFT
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              vld_i,
    input  logic [NUM_TAPS-1:0][SAMPLE_W-1:0] taps_i,
    input  logic [NUM_TAPS-1:0][COEF_W-1:0]   coefs_i,
    output logic                              vld_o,
    output logic [OUT_W-1:0]                  res_o
);

    localparam int PROD_W = SAMPLE_W + COEF_W;
    localparam int ACC_W  = PROD_W + $clog2(NUM_TAPS);
    localparam logic signed [ACC_W-1:0] HALF    = ACC_W'(1) <<< (FRAC_SHIFT - 1);
    localparam logic signed [ACC_W-1:0] OUT_MAX = ACC_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
    localparam logic signed [ACC_W-1:0] OUT_MIN = -OUT_MAX - ACC_W'(1);

    typedef struct packed {
        logic [NUM_TAPS-1:0][PROD_W-1:0] prod;
        logic                            p_vld;
        logic [ACC_W-1:0]                acc;
        logic                            a_vld;
        logic [OUT_W-1:0]                res;
        logic                            r_vld;
    } mac_t;

    mac_t mc_d, mc_q;

    logic signed [PROD_W-1:0] op_a, op_b;
    logic signed [ACC_W-1:0]  sum_c, rnd_c, shf_c;

    always_comb begin
        mc_d = mc_q;
        op_a = '0;
        op_b = '0;
        // Stage 1: nine products.
        mc_d.p_vld = vld_i;
        for (int k = 0; k < NUM_TAPS; k++) begin
            op_a = PROD_W'($signed(taps_i[k]));
            op_b = PROD_W'($signed(coefs_i[k]));
            mc_d.prod[k] = op_a * op_b;
        end
        // Stage 2: sum of all paths.
        sum_c = '0;
        for (int k = 0; k < NUM_TAPS; k++) begin
            sum_c = sum_c + ACC_W'($signed(mc_q.prod[k]));
        end
        mc_d.acc   = sum_c;
        mc_d.a_vld = mc_q.p_vld;
        // Stage 3: round half up, shift, saturate.
        rnd_c = $signed(mc_q.acc) + HALF;
        shf_c = rnd_c >>> FRAC_SHIFT;
        mc_d.r_vld = mc_q.a_vld;
        if (mc_q.a_vld) begin
            if (shf_c > OUT_MAX) begin
                mc_d.res = OUT_MAX[OUT_W-1:0];
            end else if (shf_c < OUT_MIN) begin
                mc_d.res = OUT_MIN[OUT_W-1:0];
            end else begin
                mc_d.res = shf_c[OUT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mc_q <= '0;
        end else begin
            mc_q <= mc_d;
        end
    end

    assign vld_o = mc_q.r_vld;
    assign res_o = mc_q.res;

    AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mc_q.a_vld |=> $stable(mc_q.res)); // R4

endmodule

// File: rtl/sparse_mp_fir.sv
module sparse_mp_fir #(
    parameter int SAMPLE_W   = sfir_pkg::SAMPLE_W,
    parameter int COEF_W     = sfir_pkg::COEF_W,
    parameter int OUT_W      = sfir_pkg::OUT_W,
    parameter int FRAC_SHIFT = sfir_pkg::FRAC_SHIFT,
    parameter int NUM_TAPS   = sfir_pkg::NUM_TAPS,
    parameter int LINE_LEN   = sfir_pkg::LINE_LEN,
    parameter int IDX_W      = $clog2(NUM_TAPS + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_sample,
    input  logic                       ld_valid,
    input  logic [IDX_W-1:0]           ld_idx,
    input  logic signed [COEF_W-1:0]   ld_word,
    output logic                       out_valid,
    output logic signed [OUT_W-1:0]    out_data
);

    logic [NUM_TAPS-1:0][SAMPLE_W-1:0] taps;
    logic [NUM_TAPS-1:0][COEF_W-1:0]   coefs;
    logic                              line_vld;
    logic [OUT_W-1:0]                  res;

    sfir_delay_line #(
        .SAMPLE_W (SAMPLE_W),
        .LINE_LEN (LINE_LEN),
        .NUM_TAPS (NUM_TAPS)
    ) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_i  (in_valid),
        .sample_i (in_sample),
        .taps_o   (taps),
        .vld_o    (line_vld)
    );

    sfir_coef_bank #(
        .COEF_W   (COEF_W),
        .NUM_TAPS (NUM_TAPS),
        .IDX_W    (IDX_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_valid_i (ld_valid),
        .ld_idx_i   (ld_idx),
        .ld_word_i  (ld_word),
        .swap_i     (in_valid),
        .active_o   (coefs)
    );

    sfir_mac_pipe #(
        .SAMPLE_W   (SAMPLE_W),
        .COEF_W     (COEF_W),
        .OUT_W      (OUT_W),
        .NUM_TAPS   (NUM_TAPS),
        .FRAC_SHIFT (FRAC_SHIFT)
    ) u_mac (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_i   (line_vld),
        .taps_i  (taps),
        .coefs_i (coefs),
        .vld_o   (out_valid),
        .res_o   (res)
    );

    assign out_data = $signed(res);

    AST_LAT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid, 4) |-> out_valid); // R4

    AST_LAT_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 4)); // R4

endmodule

// File: tb/tb_sparse_mp_fir.sv
module tb_sparse_mp_fir;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [13:0] in_sample = '0;
    logic               ld_valid = 1'b0;
    logic [3:0]         ld_idx = '0;
    logic signed [15:0] ld_word = '0;
    logic               out_valid;
    logic signed [16:0] out_data;

    always #10 clk = ~clk;

    sparse_mp_fir dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .ld_valid  (ld_valid),
        .ld_idx    (ld_idx),
        .ld_word   (ld_word),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    localparam int DLY [9] = '{0, 2, 4, 5, 7, 9, 11, 13, 14};

    int    checks = 0;
    int    fails  = 0;
    int    cyc    = 0;
    bit    done   = 0;
    int    exp_q [$];
    int    cyc_q [$];
    string tag_q [$];

    // Reference state built from the requirements.
    int hist  [15];
    int m_act [9];
    int m_sh  [9];
    bit m_pend = 0;
    bit m_ok   = 0;
    int m_next = 0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    function automatic int model_out();
        longint s = 0;
        for (int k = 0; k < 9; k++) s += longint'(m_act[k]) * longint'(hist[DLY[k]]);
        s = (s + 64'sd16384) >>> 15;
        if (s > 65535) s = 65535;
        if (s < -65536) s = -65536;
        return int'(s);
    endfunction

    function automatic int rnd14();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return int'($signed(lfsr[13:0]));
    endfunction

    // Driver: starts and ends at a falling edge.
    task automatic send(input int x, input string tag);
        if (m_pend) begin
            m_act  = m_sh;
            m_pend = 0;
        end
        for (int i = 14; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = x;
        exp_q.push_back(model_out());
        cyc_q.push_back(cyc + 4);
        tag_q.push_back(tag);
        in_valid  = 1'b1;
        in_sample = 14'(x);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic load(input int idx, input int w);
        if (!m_pend) begin
            if (idx == 0) begin
                m_sh[0] = w;
                m_ok    = 1;
                m_next  = 1;
            end else if (m_ok && idx == m_next) begin
                if (idx == 9) begin
                    m_pend = 1;
                    m_ok   = 0;
                end else begin
                    m_sh[idx] = w;
                    m_next++;
                end
            end else begin
                m_ok = 0;
            end
        end
        ld_valid = 1'b1;
        ld_idx   = 4'(idx);
        ld_word  = 16'(w);
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic load_profile(input int c [9]);
        for (int k = 0; k < 9; k++) load(k, c[k]);
        load(9, 0);
    endtask

    // Monitor: pops one expected item per output strobe.
    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected output", int'(out_data), 0);
            end else begin
                automatic int    e = exp_q.pop_front();
                automatic int    c = cyc_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(int'(out_data) == e, t, int'(out_data), e);
                check(cyc == c, "R4 latency", cyc, c);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int pa [9] = '{16384, -8192, 12000, 2048, -1024, 700, 300, -200, 100};
        int pb [9] = '{-9000, 5000, -3000, 2500, 1500, -800, 600, 400, -250};
        int pc [9] = '{4000, 4000, -4000, 100, -100, 200, -200, 300, -300};
        int pd [9] = '{32767, 32767, 32767, 32767, 32767, 32767, 32767, 32767, 32767};
        int pe [9] = '{-32768, 1, 2, 3, 4, 5, 6, 7, 8};
        for (int i = 0; i < 15; i++) hist[i] = 0;
        for (int k = 0; k < 9; k++) begin m_act[k] = 0; m_sh[k] = 0; end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        check(out_data == '0, "R1 out_data after reset", int'(out_data), 0);
        // R1: zero coefficients give zero output
        send(5000, "R1 zero bank");
        send(-7000, "R1 zero bank");
        idle(6);

        // R2: impulse response shows the sparse tap positions
        load_profile(pa);
        send(1000, "R8 first sample after commit");
        for (int i = 0; i < 15; i++) send(0, "R2 impulse");
        idle(5);

        // R5: half-way rounding with small inputs
        send(1, "R5 round");
        send(-1, "R5 round");
        send(3, "R5 round");
        send(-3, "R5 round");
        for (int i = 0; i < 15; i++) send(0, "R5 flush");

        // R3: gaps between samples do not disturb the line
        for (int i = 0; i < 24; i++) begin
            send(rnd14(), "R3 gapped stream");
            idle(i % 4);
        end

        // R2: back-to-back random stream
        for (int i = 0; i < 40; i++) send(rnd14(), "R2 stream");

        // R11: new profile written during streaming, not yet committed
        for (int k = 0; k < 9; k++) begin
            load(k, pb[k]);
            send(rnd14(), "R11 loads pending commit");
        end
        load(9, 0);
        // R8: commit takes effect at this very sample
        send(rnd14(), "R8 swap boundary");
        for (int i = 0; i < 10; i++) send(rnd14(), "R8 after swap");

        // R9: out-of-order sequence
        load(0, pc[0]); load(1, pc[1]); load(3, pc[3]); load(9, 0);
        for (int i = 0; i < 6; i++) send(rnd14(), "R9 out of order");
        // R9: incomplete sequence
        for (int k = 0; k < 5; k++) load(k, pc[k]);
        load(9, 0);
        for (int i = 0; i < 6; i++) send(rnd14(), "R9 incomplete");
        // R9: index above 9 breaks the sequence
        for (int k = 0; k < 4; k++) load(k, pc[k]);
        load(12, 0);
        for (int k = 4; k < 9; k++) load(k, pc[k]);
        load(9, 0);
        for (int i = 0; i < 6; i++) send(rnd14(), "R9 bad index");

        // R7: a fresh index-0 word restarts a broken sequence
        load(0, 1); load(1, 2); load(5, 3);
        load_profile(pc);
        for (int i = 0; i < 16; i++) send(rnd14(), "R7 restart then commit");

        // R10: loads ignored while a swap is armed
        load_profile(pe);
        load_profile(pb);
        send(rnd14(), "R10 armed profile applies");
        load(9, 0);
        for (int i = 0; i < 16; i++) send(rnd14(), "R10 locked words dropped");

        // R6: saturation at both rails
        load_profile(pd);
        for (int i = 0; i < 16; i++) send(8191, "R6 positive rail");
        for (int i = 0; i < 16; i++) send(-8192, "R6 negative rail");
        for (int i = 0; i < 8; i++) send(rnd14(), "R6 recover");

        idle(10);
        check(exp_q.size() == 0, "R4 one output per sample", exp_q.size(), 0);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule